// File: doc/BRIEF.md
# SPI Handshake Master

This block is a single-slave SPI master driven by the system clock. It moves one word per transfer and supports all four clock polarity and phase combinations. Words go in and come back through a parallel port. A transmit word is taken on a valid/ready handshake. Each received word is marked by a one-cycle valid pulse.

The block has two 4-pin variants, and a configuration input chooses between them:

- **Select variant.** The master drives an active-low select line. A programmable setup delay sits before the first clock edge, and a programmable hold delay sits after the last one. When the keep-select control is set and a further word is waiting, select stays asserted between words.
- **Enable variant.** Select is not driven. Instead, each word waits for an active-low ready line from the slave. That line passes through a two-flop synchronizer before the controller uses it.

**States.** The controller has six states:

- `ST_IDLE`: waiting for a word.
- `ST_WAIT_EN`: enable variant only; the word is held until the slave signals ready.
- `ST_LEAD`: counting the delay to the first clock edge.
- `ST_SHIFT`: clock edges spaced half a bit period apart.
- `ST_TAIL`: counting the delay after the final edge.
- `ST_RELEASE`: enable variant only; waiting for the slave to withdraw ready.

**Transitions.**

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_LEAD` | Word accepted, select variant |
| `ST_IDLE` | `ST_WAIT_EN` | Word accepted, enable variant |
| `ST_WAIT_EN` | `ST_LEAD` | Synchronized ready seen low |
| `ST_LEAD` | `ST_SHIFT` | First edge |
| `ST_SHIFT` | `ST_TAIL` | Final edge |
| `ST_SHIFT` | `ST_LEAD` | Final edge, keep-select set and next word accepted |
| `ST_TAIL` | `ST_IDLE` | Select variant, or enable variant with ready withdrawn |
| `ST_TAIL` | `ST_LEAD` | Enable variant, ready still low and next word accepted |
| `ST_TAIL` | `ST_RELEASE` | Enable variant, ready still low and no word waiting |
| `ST_RELEASE` | `ST_IDLE` | Ready withdrawn |

Top module: `spi_hs_master`

## Requirements
- R1: While reset is held and right after it, `sel_n` is 1, `tx_ready` is 1 and `rx_valid` is 0. With `cfg_cpol`=0, `sclk` is 0.
- R2: Outside a transfer, `sclk` rests at the level of `cfg_cpol`. It takes that level one cycle after each idle cycle.
- R3: Words of `cfg_len` bits (2 to 16) are shifted MSB first. `tx_data` and `rx_data` are right-justified, and `rx_data` bits at or above `cfg_len` read 0. Edges are numbered from 0. With `cfg_cpha`=0, even-numbered edges sample `miso` and odd-numbered edges launch `mosi`, and the MSB is on `mosi` from word acceptance. With `cfg_cpha`=1, even-numbered edges launch and odd-numbered edges sample.
- R4: A word produces exactly 2×`cfg_len` `sclk` transitions, spaced `cfg_div`+1 system cycles apart. H denotes this half-bit period.
- R5: In the select variant (`cfg_en_mode`=0), `sel_n` falls on the acceptance edge. The first `sclk` transition follows it by 2+`cfg_pre_dly` cycles, plus H when `cfg_cpha`=1.
- R6: In the select variant, `sel_n` rises 1+`cfg_post_dly` cycles after the final transition, plus H when `cfg_cpha`=0.
- R7: When `cfg_keep_sel`=1 and `tx_valid` is high at the final edge, that edge accepts the next word. `sel_n` stays low, and the next first transition follows by 2+`cfg_pre_dly` cycles (+H when `cfg_cpha`=1). Without a waiting word, R6 applies.
- R8: In the enable variant (`cfg_en_mode`=1), `sel_n` stays 1 and no `sclk` transition occurs while `en_n` is high. If `en_n` is low at rising edge a, the first transition comes at edge a+3, plus H when `cfg_cpha`=1.
- R9: In the enable variant, synchronized `en_n` is checked 1 cycle after the final transition, plus H when `cfg_cpha`=0. If it is low and `tx_valid` is high, the next word is accepted and its first transition comes 1 cycle later (+H when `cfg_cpha`=1). If it is low with no word waiting, no word is accepted until `en_n` has gone high.
- R10: `rx_valid` is a one-cycle pulse starting on the final sampling edge, edge 2×`cfg_len`−2+`cfg_cpha`.
- R11: `tx_ready` is high only in idle, at the keep-select point of R7, or at the enable check of R9. In the select variant without keep-select, it is never high while `sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: first edge samples; 1: first edge launches |
| cfg_en_mode | input | 1 | 0: select variant; 1: enable variant |
| cfg_keep_sel | input | 1 | Keep select low across back-to-back words |
| cfg_div | input | DIVW | Half-bit period minus one, in system cycles |
| cfg_len | input | LW | Word length in bits, 2 to DW |
| cfg_pre_dly | input | DLYW | Extra cycles from select to first edge |
| cfg_post_dly | input | DLYW | Extra cycles from final edge to select release |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DW | Transmit word, right-justified |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | DW | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 1 | Active-low slave select |
| en_n | input | 1 | Active-low slave ready |

## Verification
The bench measures every gap in system cycles against the formulas above. This catches the phase-dependent half-bit term when it is placed on the wrong side of the transfer, because it moves either the lead or the release by H. It also catches a synchronizer that adds or drops a stage, because the enable-to-clock delay shifts away from three cycles. Back-to-back runs catch a keep-select path that briefly releases `sel_n`, and an enable check that fails to refuse a new word while the slave still holds ready low. The shortest word length and a zero divider catch off-by-one errors in the last-edge and last-sample compares, which show up as a missing `rx_valid` or a corrupted MSB.

// File: rtl/spi_hs_pkg.sv
`timescale 1ns/1ps
package spi_hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_EN,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_RELEASE
    } spi_hs_st_t;
endpackage

// File: rtl/spi_hs_sync.sv
`timescale 1ns/1ps
module spi_hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_hs_timing.sv
`timescale 1ns/1ps
// Counter reload values. A value v loaded on edge e fires its action on edge e+v+1.
module spi_hs_timing #(
    parameter int DIVW = 8,
    parameter int DLYW = 5,
    parameter int CW   = 10
) (
    input  logic            cpha,
    input  logic [DIVW-1:0] div,
    input  logic [DLYW-1:0] pre_dly,
    input  logic [DLYW-1:0] post_dly,
    output logic [CW-1:0]   half_ld,
    output logic [CW-1:0]   cs_lead_ld,
    output logic [CW-1:0]   cs_tail_ld,
    output logic [CW-1:0]   en_lead_ld,
    output logic [CW-1:0]   en_tail_ld
);
    logic [CW-1:0] half;

    assign half       = CW'(div) + CW'(1);
    assign half_ld    = CW'(div);
    assign cs_lead_ld = CW'(1) + CW'(pre_dly) + (cpha ? half : '0);
    assign cs_tail_ld = CW'(post_dly) + (cpha ? '0 : half);
    assign en_lead_ld = cpha ? half : '0;
    assign en_tail_ld = cpha ? '0 : half;
endmodule

// File: rtl/spi_hs_master.sv
`timescale 1ns/1ps
module spi_hs_master
    import spi_hs_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 8,
    parameter int DLYW = 5,
    parameter int LW   = $clog2(DW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            cfg_en_mode,
    input  logic            cfg_keep_sel,
    input  logic [DIVW-1:0] cfg_div,
    input  logic [LW-1:0]   cfg_len,
    input  logic [DLYW-1:0] cfg_pre_dly,
    input  logic [DLYW-1:0] cfg_post_dly,
    input  logic            tx_valid,
    input  logic [DW-1:0]   tx_data,
    output logic            tx_ready,
    output logic            rx_valid,
    output logic [DW-1:0]   rx_data,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic            sel_n,
    input  logic            en_n
);
    localparam int CW = ((DIVW > DLYW) ? DIVW : DLYW) + 2;
    localparam int IW = $clog2(2 * DW);

    spi_hs_st_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          sclk_q, sclk_d, sel_q, sel_d, mosi_q, mosi_d, rxv_q, rxv_d;
    logic [DW-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, aligned, len_mask;
    logic [CW-1:0] half_ld, cs_lead_ld, cs_tail_ld, en_lead_ld, en_tail_ld;
    logic [IW:0]   last_idx, last_smp;
    logic          en_s, at_last, accept;

    spi_hs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d_in(en_n), .q_out(en_s)
    );

    spi_hs_timing #(.DIVW(DIVW), .DLYW(DLYW), .CW(CW)) u_timing (
        .cpha(cfg_cpha), .div(cfg_div), .pre_dly(cfg_pre_dly), .post_dly(cfg_post_dly),
        .half_ld(half_ld), .cs_lead_ld(cs_lead_ld), .cs_tail_ld(cs_tail_ld),
        .en_lead_ld(en_lead_ld), .en_tail_ld(en_tail_ld)
    );

    always_comb begin
        for (int i = 0; i < DW; i++) len_mask[i] = (i < int'(cfg_len));
        last_idx = (IW+1)'(2 * int'(cfg_len) - 1);
        last_smp = (IW+1)'(2 * int'(cfg_len) - 2 + int'(cfg_cpha));
        aligned  = tx_data << (DW - int'(cfg_len));
        at_last  = ({1'b0, idx_q} == last_idx);
    end

    assign tx_ready = (st_q == ST_IDLE)
                    || (!cfg_en_mode && cfg_keep_sel && st_q == ST_SHIFT && cnt_q == '0 && at_last)
                    || (cfg_en_mode && st_q == ST_TAIL && cnt_q == '0 && !en_s);
    assign accept   = tx_valid && tx_ready;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sclk_q  <= 1'b0;
            sel_q   <= 1'b1;
            mosi_q  <= 1'b0;
            rxv_q   <= 1'b0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sclk_q  <= sclk_d;
            sel_q   <= sel_d;
            mosi_q  <= mosi_d;
            rxv_q   <= rxv_d;
            tx_sh_q <= tx_sh_d;
            rx_sh_q <= rx_sh_d;
        end
    end

    // Next-state and output process
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sclk_d  = sclk_q;
        sel_d   = sel_q;
        mosi_d  = mosi_q;
        rxv_d   = 1'b0;
        tx_sh_d = tx_sh_q;
        rx_sh_d = rx_sh_q;
        unique case (st_q)
            ST_IDLE: begin
                sclk_d = cfg_cpol;
                sel_d  = 1'b1;
                if (tx_valid) begin
                    st_d  = cfg_en_mode ? ST_WAIT_EN : ST_LEAD;
                    sel_d = cfg_en_mode;
                    cnt_d = cs_lead_ld;
                    idx_d = '0;
                end
            end
            ST_WAIT_EN: begin
                if (!en_s) begin
                    st_d  = ST_LEAD;
                    cnt_d = en_lead_ld;
                end
            end
            ST_LEAD, ST_SHIFT: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CW'(1);
                end else begin
                    sclk_d = ~sclk_q;
                    if (idx_q[0] == cfg_cpha) begin
                        rx_sh_d = {rx_sh_q[DW-2:0], miso};
                        rxv_d   = ({1'b0, idx_q} == last_smp);
                    end else begin
                        mosi_d  = tx_sh_q[DW-1];
                        tx_sh_d = tx_sh_q << 1;
                    end
                    if (at_last) begin
                        if (!cfg_en_mode && cfg_keep_sel && tx_valid) begin
                            st_d  = ST_LEAD;
                            cnt_d = cs_lead_ld;
                            idx_d = '0;
                        end else begin
                            st_d  = ST_TAIL;
                            cnt_d = cfg_en_mode ? en_tail_ld : cs_tail_ld;
                        end
                    end else begin
                        st_d  = ST_SHIFT;
                        idx_d = idx_q + IW'(1);
                        cnt_d = half_ld;
                    end
                end
            end
            ST_TAIL: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CW'(1);
                end else if (!cfg_en_mode) begin
                    sel_d = 1'b1;
                    st_d  = ST_IDLE;
                end else if (!en_s && tx_valid) begin
                    st_d  = ST_LEAD;
                    cnt_d = en_lead_ld;
                    idx_d = '0;
                end else if (!en_s) begin
                    st_d  = ST_RELEASE;
                end else begin
                    st_d  = ST_IDLE;
                end
            end
            ST_RELEASE: begin
                if (en_s) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        if (accept) begin
            tx_sh_d = aligned;
            if (!cfg_cpha) begin
                mosi_d  = aligned[DW-1];
                tx_sh_d = aligned << 1;
            end
        end
    end

    assign sclk     = sclk_q;
    assign sel_n    = sel_q;
    assign mosi     = mosi_q;
    assign rx_valid = rxv_q;
    assign rx_data  = rx_sh_q & len_mask;

    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (sclk == $past(cfg_cpol)));
    p_edge_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LEAD || st_q == ST_SHIFT) && cnt_q != '0) |=> $stable(sclk));
    p_shift_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en_mode && st_q == ST_SHIFT) |-> !sel_n);
    p_sel_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> ($past(st_q) == ST_TAIL));
    p_wait_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_EN || st_q == ST_RELEASE) |-> sel_n);
    p_rx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_ready_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !cfg_en_mode && !sel_n) |-> cfg_keep_sel);
endmodule

// File: tb/spi_hs_master_bench.sv
`timescale 1ns/1ps
module spi_hs_master_bench;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic cfg_cpol = 0, cfg_cpha = 0, cfg_en_mode = 0, cfg_keep_sel = 0;
    logic [7:0] cfg_div = 0;
    logic [4:0] cfg_len = 8, cfg_pre_dly = 0, cfg_post_dly = 0;
    logic tx_valid = 0, miso = 0, en_n = 1;
    logic [DW-1:0] tx_data = 0;
    logic tx_ready, rx_valid, sclk, mosi, sel_n;
    logic [DW-1:0] rx_data;

    spi_hs_master u_spi_hs_master (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_en_mode(cfg_en_mode), .cfg_keep_sel(cfg_keep_sel), .cfg_div(cfg_div),
        .cfg_len(cfg_len), .cfg_pre_dly(cfg_pre_dly), .cfg_post_dly(cfg_post_dly),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .sel_n(sel_n), .en_n(en_n)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor and slave model, evaluated away from the active edge
    int L = 8;
    logic [DW-1:0] slv_tx = 0;
    logic [DW-1:0] srx [0:7];
    int et [0:127];
    int rv_t [0:7];
    logic [DW-1:0] rv_d [0:7];
    int ne, rv_n, sel_fall_t, sel_rise_t, n_fall, n_rise, ready_bad;
    int mi, mw, mb;
    logic prev_sclk = 0, prev_sel = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk !== prev_sclk && ne < 128) begin
                et[ne] = cyc;
                mi = ne % (2 * L);
                mw = (ne / (2 * L)) % 8;
                if (mi % 2 == int'(cfg_cpha)) begin
                    srx[mw] = {srx[mw][DW-2:0], mosi};
                end else begin
                    mb = cfg_cpha ? mi / 2 : (mi + 1) / 2;
                    if (mb >= L) mb = 0;
                    miso = slv_tx[L-1-mb];
                end
                ne++;
            end
            if (prev_sel && !sel_n) begin sel_fall_t = cyc; n_fall++; end
            if (!prev_sel && sel_n) begin sel_rise_t = cyc; n_rise++; end
            if (rx_valid && rv_n < 8) begin rv_t[rv_n] = cyc; rv_d[rv_n] = rx_data; rv_n++; end
            if (tx_ready && !sel_n && !cfg_keep_sel && !cfg_en_mode) ready_bad++;
        end
        prev_sclk = sclk;
        prev_sel  = sel_n;
    end

    function automatic logic [DW-1:0] msk(logic [DW-1:0] v, int len);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = (i < len);
        return v & m;
    endfunction

    task automatic clr_mon(int len, logic [DW-1:0] slw);
        L = len; slv_tx = slw;
        ne = 0; rv_n = 0; n_fall = 0; n_rise = 0; ready_bad = 0;
        sel_fall_t = -1; sel_rise_t = -1;
        for (int k = 0; k < 8; k++) srx[k] = '0;
        miso = slw[len-1];
    endtask

    task automatic send(logic [DW-1:0] w, output int t_acc);
        tx_data = w; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        t_acc = cyc;
    endtask

    task automatic wait_edges(int n);
        while (ne < n) @(negedge clk);
    endtask

    task automatic setcfg(logic pol, logic pha, logic enm, logic keep, int len, int dv, int pre, int post);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_en_mode = enm; cfg_keep_sel = keep;
        cfg_len = 5'(len); cfg_div = 8'(dv); cfg_pre_dly = 5'(pre); cfg_post_dly = 5'(post);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sel_n at reset", int'(sel_n), 1);
        chk("R1 tx_ready at reset", int'(tx_ready), 1);
        chk("R1 rx_valid at reset", int'(rx_valid), 0);
        chk("R1 sclk at reset", int'(sclk), 0);
    endtask

    task automatic t_cs(logic pol, logic pha, int len, int dv, int pre, int post, logic keep,
                        logic [DW-1:0] txw, logic [DW-1:0] slw);
        int ta, h;
        h = dv + 1;
        setcfg(pol, pha, 1'b0, keep, len, dv, pre, post);
        chk("R2 idle level before", int'(sclk), int'(pol));
        clr_mon(len, slw);
        send(txw, ta);
        while (!sel_n) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R5 sel fall on accept", sel_fall_t, ta);
        chk("R5 lead", et[0] - sel_fall_t, 2 + pre + (pha ? h : 0));
        chk("R4 edge count", ne, 2 * len);
        for (int k = 1; k < 2 * len; k++)
            if (et[k] - et[k-1] != h) chk("R4 spacing", et[k] - et[k-1], h);
        chk("R6 tail", sel_rise_t - et[2*len-1], 1 + post + (pha ? 0 : h));
        chk("R3 mosi word", int'(srx[0]), int'(msk(txw, len)));
        chk("R3 rx word", int'(rv_d[0]), int'(msk(slw, len)));
        chk("R10 rx pulses", rv_n, 1);
        chk("R10 rx time", rv_t[0], et[2*len-2+int'(pha)]);
        chk("R11 ready while selected", ready_bad, 0);
        chk("R2 idle level after", int'(sclk), int'(pol));
    endtask

    task automatic t_cs_pair(logic pol, logic pha, int len, int dv, int pre,
                             logic [DW-1:0] wa, logic [DW-1:0] wb, logic [DW-1:0] slw);
        int ta, tb, h;
        h = dv + 1;
        setcfg(pol, pha, 1'b0, 1'b1, len, dv, pre, 3);
        clr_mon(len, slw);
        send(wa, ta);
        send(wb, tb);
        while (!sel_n) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 single select window", n_rise, 1);
        chk("R7 edge count", ne, 4 * len);
        chk("R7 accept at final edge", tb, et[2*len-1]);
        chk("R7 gap", et[2*len] - et[2*len-1], 2 + pre + (pha ? h : 0));
        chk("R3 first word", int'(srx[0]), int'(msk(wa, len)));
        chk("R3 second word", int'(srx[1]), int'(msk(wb, len)));
        chk("R10 two pulses", rv_n, 2);
        chk("R10 second rx", int'(rv_d[1]), int'(msk(slw, len)));
    endtask

    task automatic t_en(logic pol, logic pha, int len, int dv, logic [DW-1:0] txw, logic [DW-1:0] slw);
        int ta, t_en, h;
        h = dv + 1;
        en_n = 1'b1;
        setcfg(pol, pha, 1'b1, 1'b0, len, dv, 0, 0);
        clr_mon(len, slw);
        send(txw, ta);
        repeat (10) @(negedge clk);
        chk("R8 waits for enable", ne, 0);
        en_n = 1'b0;
        t_en = cyc + 1;
        wait_edges(2 * len);
        repeat (h + 6) @(negedge clk);
        chk("R8 enable lead", et[0] - t_en, 3 + (pha ? h : 0));
        chk("R8 select unused", n_fall, 0);
        chk("R3 mosi word", int'(srx[0]), int'(msk(txw, len)));
        chk("R3 rx word", int'(rv_d[0]), int'(msk(slw, len)));
        en_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 back to idle", int'(tx_ready), 1);
    endtask

    task automatic t_en_pair(logic pol, logic pha, int len, int dv,
                             logic [DW-1:0] wa, logic [DW-1:0] wb, logic [DW-1:0] wc, logic [DW-1:0] slw);
        int ta, tb, h, c;
        h = dv + 1;
        en_n = 1'b0;
        setcfg(pol, pha, 1'b1, 1'b0, len, dv, 0, 0);
        clr_mon(len, slw);
        send(wa, ta);
        send(wb, tb);
        wait_edges(4 * len);
        c = et[2*len-1] + 1 + (pha ? 0 : h);
        chk("R9 accept at check", tb, c);
        chk("R9 next lead", et[2*len] - c, 1 + (pha ? h : 0));
        chk("R3 second word", int'(srx[1]), int'(msk(wb, len)));
        repeat (h + 4) @(negedge clk);
        tx_data = wc; tx_valid = 1'b1;
        repeat (12) @(negedge clk);
        chk("R9 no start while held", ne, 4 * len);
        chk("R9 ready low while held", int'(tx_ready), 0);
        en_n = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        en_n = 1'b0;
        wait_edges(6 * len);
        repeat (h + 6) @(negedge clk);
        chk("R9 third word", int'(srx[2]), int'(msk(wc, len)));
        chk("R10 three pulses", rv_n, 3);
        en_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cs(1'b0, 1'b0, 8, 1, 0, 0, 1'b0, 16'h00A5, 16'h003C);
        t_cs(1'b0, 1'b1, 8, 2, 3, 2, 1'b0, 16'h0096, 16'h00C3);
        t_cs(1'b1, 1'b0, 12, 0, 5, 7, 1'b0, 16'h0B5D, 16'h0E21);
        t_cs(1'b1, 1'b1, 16, 3, 31, 31, 1'b0, 16'hC0DE, 16'h5AF1);
        t_cs(1'b1, 1'b0, 5, 1, 2, 4, 1'b1, 16'h0015, 16'h000A);
        t_cs(1'b0, 1'b0, 2, 0, 0, 0, 1'b0, 16'h0002, 16'h0001);
        t_cs_pair(1'b0, 1'b1, 8, 1, 2, 16'h00E7, 16'h0018, 16'h0069);
        t_cs_pair(1'b1, 1'b0, 6, 0, 0, 16'h002D, 16'h0033, 16'h0015);
        t_en(1'b0, 1'b0, 8, 1, 16'h00B4, 16'h004B);
        t_en(1'b1, 1'b1, 10, 2, 16'h02F1, 16'h010E);
        t_en_pair(1'b0, 1'b1, 8, 1, 16'h0081, 16'h007E, 16'h00C6, 16'h0055);
        t_en_pair(1'b1, 1'b0, 4, 0, 16'h0009, 16'h0006, 16'h000F, 16'h000C);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule